// File: doc/BRIEF.md
# Trigger-Validated Double-Column Readout Controller

This block is the digital periphery of a pixel readout chip whose sensor area is split into a parameterised number of double columns (26 by default). Each column keeps one pending hit. The hit holds the bunch-crossing count at which it arrived and an opaque data word that stands in for the pixel payload. A free-running 8-bit crossing counter supplies the time stamps. A lagging copy of it, offset backwards by a programmable trigger delay, is compared against every pending time stamp when a level-1 trigger arrives.

Columns that match on a trigger are frozen and tagged with the current 4-bit trigger number. Pending hits that do not match are dropped. Every trigger advances the trigger number, whether or not any column matched.

A readout token starts a pass over the whole chip. The controller first emits a one-beat chip header. It then visits every column in ascending index order and sends and resets each frozen column whose tag equals the token number. Finally it passes the token on with a one-cycle pulse. The trigger number and the token number are kept apart, so a token collects only its own trigger's columns even when later triggers have already frozen other columns.

Top module: `dcol_readout_ctrl`

## Requirements
- R1: During synchronous reset (rst_n low), and in the first cycle after it, dout_valid_o and token_o are 0. The crossing counter, the trigger number and the token number all start at 0.
- R2: A hit on column c in the cycle whose crossing count is h stores h and that column's col_data_i word. A trigger sampled when the crossing count is h plus cfg_delay_i validates the column, and the next token sends the stored word with dout_col_o equal to c.
- R3: A trigger that finds a pending time stamp that differs from the lagging count discards the hit. No token sends that column, and the column accepts a new hit afterwards.
- R4: A validated column is frozen. Later hits on it change neither its stored word nor its tag until a token has read it out.
- R5: Columns that have not been validated keep recording hits while other columns are frozen, and a later trigger can validate them.
- R6: A validated column is tagged with the trigger number of the cycle in which it was validated. A token reads out only the frozen columns whose tag equals the token number, so two triggers followed by two tokens deliver the two column sets separately, in trigger order.
- R7: When token_i is sampled high while the controller is idle, the next cycle shows a header beat: dout_valid_o=1, dout_hdr_o=1, dout_data_o=0x0006 (header code 3'b110 in bits 2:0). Selected columns follow in strictly ascending index order with dout_hdr_o=0. Each column sent is reset, so a later token does not send it again.
- R8: token_o is high for exactly one cycle. That cycle is NUM_COLS+1 cycles after the header beat. The token number advances by one at that point, and token_i is ignored while a pass is in progress.
- R9: The trigger number and the token number wrap modulo 16. A column validated 16 triggers after another column carries the same tag, and both are read by the same token.
- R10: The crossing counter wraps modulo 256, and the lagging count is the crossing count minus cfg_delay_i modulo 256. A hit at crossing 250 with a delay of 10 is validated by a trigger at crossing 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_delay_i | input | TS_W | Trigger delay in crossings |
| hit_i | input | NUM_COLS | Per-column hit strobe |
| col_data_i | input | NUM_COLS*DATA_W | Per-column data word, captured with the hit |
| l1_trig_i | input | 1 | Level-1 trigger strobe |
| token_i | input | 1 | Readout token in |
| token_o | output | 1 | Readout token out, one-cycle pulse |
| dout_valid_o | output | 1 | Output beat valid |
| dout_hdr_o | output | 1 | Beat is the chip header |
| dout_col_o | output | COL_W | Column index of a data beat |
| dout_data_o | output | DATA_W | Header code or column data word |

## Verification
A wrong time stamp, lagging count or tag shows up at the next token. The affected column is missing from that pass, turns up in a different pass, or carries a stale data word, so the error is visible at most one readout pass after the faulty trigger. A scan-order or reset error shows within the same pass, as a descending index or as a column that is sent again by the following token. Counter wrap errors are exercised by pushing the tag through a full cycle of 16 triggers and the crossing counter across 255, where a wrong width would make a column vanish.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam logic [2:0] CHIP_HDR = 3'b110;

    typedef enum logic [1:0] {
        RO_IDLE,
        RO_SCAN,
        RO_DONE
    } ro_state_e;
endpackage

// File: rtl/dcr_counters.sv
module dcr_counters #(
    parameter int TS_W  = 8,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1_trig_i,
    input  logic             tok_adv_i,
    input  logic [TS_W-1:0]  delay_i,
    output logic [TS_W-1:0]  bx_o,
    output logic [TS_W-1:0]  lag_o,
    output logic [TAG_W-1:0] trig_num_o,
    output logic [TAG_W-1:0] tok_num_o
);
    typedef struct packed {
        logic [TS_W-1:0]  bx;
        logic [TAG_W-1:0] trig;
        logic [TAG_W-1:0] tok;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        cnt_d.bx = cnt_q.bx + 1'b1;
        if (l1_trig_i) cnt_d.trig = cnt_q.trig + 1'b1;
        if (tok_adv_i) cnt_d.tok  = cnt_q.tok + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bx_o       = cnt_q.bx;
    assign lag_o      = cnt_q.bx - delay_i;
    assign trig_num_o = cnt_q.trig;
    assign tok_num_o  = cnt_q.tok;

    // R9: the trigger number moves only on a trigger
    assert_trig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_trig_i |=> $stable(trig_num_o));
    // R6: the token number moves only when a pass completes
    assert_tok_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_adv_i |=> $stable(tok_num_o));
endmodule

// File: rtl/dcr_column.sv
module dcr_column #(
    parameter int TS_W   = 8,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              trig_i,
    input  logic [TS_W-1:0]   bx_i,
    input  logic [TS_W-1:0]   lag_i,
    input  logic [TAG_W-1:0]  trig_num_i,
    input  logic              clr_i,
    output logic              frozen_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              pend;
        logic              frozen;
        logic [TS_W-1:0]   ts;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } col_st_t;

    col_st_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (col_q.frozen) begin
            if (clr_i) begin
                col_d.frozen = 1'b0;
                col_d.pend   = 1'b0;
            end
        end else begin
            if (trig_i && col_q.pend) begin
                if (col_q.ts == lag_i) begin
                    col_d.frozen = 1'b1;
                    col_d.tag    = trig_num_i;
                end else begin
                    col_d.pend = 1'b0;
                end
            end
            if (hit_i && !col_d.frozen) begin
                col_d.pend = 1'b1;
                col_d.ts   = bx_i;
                col_d.data = data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign frozen_o = col_q.frozen;
    assign tag_o    = col_q.tag;
    assign data_o   = col_q.data;

    // R4: a frozen column keeps its tag and word until the readout clears it
    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !clr_i) |=> (frozen_o && $stable(tag_o) && $stable(data_o)));
    // R2: a hit on a live column is never lost in the same cycle
    assert_hit_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !frozen_o) |=> (col_q.pend && (frozen_o || col_q.ts == $past(bx_i))));
endmodule

// File: rtl/dcr_readout.sv
module dcr_readout
    import dcr_pkg::*;
#(
    parameter int NUM_COLS = 26,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 4,
    parameter int COL_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         token_i,
    input  logic [NUM_COLS-1:0]          frozen_i,
    input  logic [NUM_COLS*TAG_W-1:0]    tag_i,
    input  logic [NUM_COLS*DATA_W-1:0]   data_i,
    input  logic [TAG_W-1:0]             tok_num_i,
    output logic [NUM_COLS-1:0]          clr_o,
    output logic                         tok_adv_o,
    output logic                         token_o,
    output logic                         dout_valid_o,
    output logic                         dout_hdr_o,
    output logic [COL_W-1:0]             dout_col_o,
    output logic [DATA_W-1:0]            dout_data_o
);
    typedef struct packed {
        ro_state_e           state;
        logic [COL_W-1:0]    idx;
        logic [NUM_COLS-1:0] mask;
        logic                dval;
        logic                dhdr;
        logic [COL_W-1:0]    dcol;
        logic [DATA_W-1:0]   ddata;
        logic                tout;
    } ro_st_t;

    ro_st_t ro_d, ro_q;
    logic [NUM_COLS-1:0] sel;

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_sel
        assign sel[i] = frozen_i[i] && (tag_i[i*TAG_W +: TAG_W] == tok_num_i);
    end

    always_comb begin
        ro_d       = ro_q;
        ro_d.dval  = 1'b0;
        ro_d.dhdr  = 1'b0;
        ro_d.dcol  = '0;
        ro_d.ddata = '0;
        ro_d.tout  = 1'b0;
        clr_o      = '0;
        tok_adv_o  = 1'b0;
        case (ro_q.state)
            RO_IDLE: begin
                if (token_i) begin
                    ro_d.state = RO_SCAN;
                    ro_d.idx   = '0;
                    ro_d.mask  = sel;
                    ro_d.dval  = 1'b1;
                    ro_d.dhdr  = 1'b1;
                    ro_d.ddata = DATA_W'(CHIP_HDR);
                end
            end
            RO_SCAN: begin
                if (ro_q.mask[ro_q.idx]) begin
                    ro_d.dval         = 1'b1;
                    ro_d.dcol         = ro_q.idx;
                    ro_d.ddata        = data_i[ro_q.idx*DATA_W +: DATA_W];
                    clr_o[ro_q.idx]   = 1'b1;
                end
                if (ro_q.idx == COL_W'(NUM_COLS-1)) ro_d.state = RO_DONE;
                else                                ro_d.idx   = ro_q.idx + 1'b1;
            end
            RO_DONE: begin
                ro_d.state = RO_IDLE;
                ro_d.tout  = 1'b1;
                tok_adv_o  = 1'b1;
            end
            default: ro_d.state = RO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ro_q <= '0;
        else        ro_q <= ro_d;
    end

    assign token_o      = ro_q.tout;
    assign dout_valid_o = ro_q.dval;
    assign dout_hdr_o   = ro_q.dhdr;
    assign dout_col_o   = ro_q.dcol;
    assign dout_data_o  = ro_q.ddata;

    // R8: the passed-on token is a single-cycle pulse
    assert_token_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        token_o |=> !token_o);
    // R7: a header beat always follows a sampled token
    assert_hdr_after_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_hdr_o) |-> $past(token_i));
    // R7: data beats come in strictly ascending column order
    assert_scan_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid_o && !dout_hdr_o) |=>
            (!dout_valid_o || dout_hdr_o || dout_col_o > $past(dout_col_o)));
endmodule

// File: rtl/dcol_readout_ctrl.sv
module dcol_readout_ctrl #(
    parameter int NUM_COLS = 26,
    parameter int DATA_W   = 16,
    parameter int TS_W     = 8,
    parameter int TAG_W    = 4,
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TS_W-1:0]            cfg_delay_i,
    input  logic [NUM_COLS-1:0]        hit_i,
    input  logic [NUM_COLS*DATA_W-1:0] col_data_i,
    input  logic                       l1_trig_i,
    input  logic                       token_i,
    output logic                       token_o,
    output logic                       dout_valid_o,
    output logic                       dout_hdr_o,
    output logic [COL_W-1:0]           dout_col_o,
    output logic [DATA_W-1:0]          dout_data_o
);
    logic [TS_W-1:0]            bx, lag;
    logic [TAG_W-1:0]           trig_num, tok_num;
    logic                       tok_adv;
    logic [NUM_COLS-1:0]        frozen, clr;
    logic [NUM_COLS*TAG_W-1:0]  tags;
    logic [NUM_COLS*DATA_W-1:0] words;

    dcr_counters #(.TS_W(TS_W), .TAG_W(TAG_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .l1_trig_i  (l1_trig_i),
        .tok_adv_i  (tok_adv),
        .delay_i    (cfg_delay_i),
        .bx_o       (bx),
        .lag_o      (lag),
        .trig_num_o (trig_num),
        .tok_num_o  (tok_num)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        dcr_column #(.TS_W(TS_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit_i      (hit_i[c]),
            .data_i     (col_data_i[c*DATA_W +: DATA_W]),
            .trig_i     (l1_trig_i),
            .bx_i       (bx),
            .lag_i      (lag),
            .trig_num_i (trig_num),
            .clr_i      (clr[c]),
            .frozen_o   (frozen[c]),
            .tag_o      (tags[c*TAG_W +: TAG_W]),
            .data_o     (words[c*DATA_W +: DATA_W])
        );
    end

    dcr_readout #(
        .NUM_COLS (NUM_COLS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .COL_W    (COL_W)
    ) u_readout (
        .clk          (clk),
        .rst_n        (rst_n),
        .token_i      (token_i),
        .frozen_i     (frozen),
        .tag_i        (tags),
        .data_i       (words),
        .tok_num_i    (tok_num),
        .clr_o        (clr),
        .tok_adv_o    (tok_adv),
        .token_o      (token_o),
        .dout_valid_o (dout_valid_o),
        .dout_hdr_o   (dout_hdr_o),
        .dout_col_o   (dout_col_o),
        .dout_data_o  (dout_data_o)
    );

    // R1: nothing leaves the block in the first cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dout_valid_o && !token_o));
endmodule

// File: tb/dcol_readout_ctrl_bench.sv
module dcol_readout_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 26;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      cfg_delay = 8'd5;
    logic [NC-1:0]   hit = '0;
    logic [NC*DW-1:0] col_data;
    logic            l1_trig = 1'b0;
    logic            token_in = 1'b0;
    logic            token_out, dout_valid, dout_hdr;
    logic [4:0]      dout_col;
    logic [DW-1:0]   dout_data;

    logic [DW-1:0]   cur_data [NC];
    logic [DW-1:0]   rx_data [NC];
    logic [NC-1:0]   rx_mask;
    bit              hdr_ok, order_ok, tok_early, tok_end, tok_after, idle_after;
    int              checks = 0, errors = 0, cyc = 0;
    bit              reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    always_comb
        for (int c = 0; c < NC; c++) col_data[c*DW +: DW] = cur_data[c];

    dcol_readout_ctrl u_dcol_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_delay_i(cfg_delay), .hit_i(hit),
        .col_data_i(col_data), .l1_trig_i(l1_trig), .token_i(token_in),
        .token_o(token_out), .dout_valid_o(dout_valid), .dout_hdr_o(dout_hdr),
        .dout_col_o(dout_col), .dout_data_o(dout_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    task automatic hit_cols(input logic [NC-1:0] m, input logic [DW-1:0] base);
        for (int c = 0; c < NC; c++) if (m[c]) cur_data[c] = DW'(base + DW'(c));
        hit = m;
        @(negedge clk);
        hit = '0;
    endtask

    task automatic trig_after(input int n);
        repeat (n - 1) @(negedge clk);
        l1_trig = 1'b1;
        @(negedge clk);
        l1_trig = 1'b0;
    endtask

    task automatic do_token(input bit poke);
        int last;
        token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        hdr_ok = dout_valid && dout_hdr && (dout_data == 16'h0006);
        rx_mask = '0; order_ok = 1'b1; tok_early = 1'b0; last = -1;
        for (int k = 0; k < NC; k++) begin
            if (poke && k == 5) token_in = 1'b1;
            if (poke && k == 6) token_in = 1'b0;
            @(negedge clk);
            if (token_out) tok_early = 1'b1;
            if (dout_valid) begin
                if (dout_hdr || int'(dout_col) <= last) order_ok = 1'b0;
                rx_mask[dout_col] = 1'b1;
                rx_data[dout_col] = dout_data;
                last = int'(dout_col);
            end
        end
        @(negedge clk);
        tok_end = token_out;
        idle_after = 1'b1;
        @(negedge clk);
        tok_after = token_out;
        repeat (3) begin
            if (dout_valid) idle_after = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic check_pass(input string req, input logic [NC-1:0] exp_mask);
        check(hdr_ok, "R7", "header beat", {31'd0, hdr_ok}, 1);
        check(order_ok, "R7", "ascending order", {31'd0, order_ok}, 1);
        check(!tok_early && tok_end && !tok_after, "R8", "token_out pulse",
              {29'd0, tok_early, tok_end, tok_after}, 3'b010);
        check(rx_mask == exp_mask, req, "columns read", rx_mask, exp_mask);
    endtask

    task automatic t_reset_r1();
        repeat (3) @(negedge clk);
        check(!dout_valid && !token_out, "R1", "outputs in reset",
              {30'd0, dout_valid, token_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dout_valid && !token_out, "R1", "outputs after reset",
              {30'd0, dout_valid, token_out}, 0);
    endtask

    task automatic t_basic_r2();
        logic [NC-1:0] m = '0;
        m[0] = 1'b1; m[3] = 1'b1; m[17] = 1'b1; m[25] = 1'b1;
        cfg_delay = 8'd5;
        hit_cols(m, 16'h1000);
        trig_after(5);
        do_token(1'b0);
        check_pass("R2", m);
        check(rx_data[0] == 16'h1000 && rx_data[25] == 16'h1019, "R2", "boundary words",
              {rx_data[0], rx_data[25]}, {16'h1000, 16'h1019});
        check(rx_data[17] == 16'h1011, "R2", "col 17 word", rx_data[17], 16'h1011);
    endtask

    task automatic t_mismatch_r3();
        logic [NC-1:0] m = '0;
        m[5] = 1'b1;
        hit_cols(m, 16'h2000);
        trig_after(6);
        do_token(1'b0);
        check(rx_mask == '0, "R3", "late trigger discards", rx_mask, 0);
        hit_cols(m, 16'h2100);
        trig_after(5);
        do_token(1'b0);
        check_pass("R3", m);
        check(rx_data[5] == 16'h2105, "R3", "new hit after discard", rx_data[5], 16'h2105);
    endtask

    task automatic t_freeze_r4_r5_r6();
        logic [NC-1:0] a = '0, b = '0, ab = '0;
        a[2] = 1'b1; b[9] = 1'b1; ab[2] = 1'b1; ab[9] = 1'b1;
        hit_cols(a, 16'h3000);
        trig_after(5);
        hit_cols(ab, 16'h3100);
        trig_after(5);
        do_token(1'b0);
        check_pass("R6", a);
        check(rx_data[2] == 16'h3002, "R4", "frozen word kept", rx_data[2], 16'h3002);
        do_token(1'b0);
        check_pass("R5", b);
        check(rx_data[9] == 16'h3109, "R5", "live column recorded", rx_data[9], 16'h3109);
    endtask

    task automatic t_reset_after_read_r7_r8();
        trig_after(1);
        do_token(1'b1);
        check_pass("R7", '0);
        check(idle_after, "R8", "token during pass ignored", {31'd0, idle_after}, 1);
    endtask

    task automatic t_tag_wrap_r9();
        logic [NC-1:0] a = '0, b = '0, ab = '0;
        a[1] = 1'b1; b[4] = 1'b1; ab[1] = 1'b1; ab[4] = 1'b1;
        hit_cols(a, 16'h4000);
        trig_after(5);
        for (int i = 0; i < 15; i++) trig_after(1);
        hit_cols(b, 16'h4100);
        trig_after(5);
        do_token(1'b0);
        check_pass("R9", ab);
        check(rx_data[1] == 16'h4001 && rx_data[4] == 16'h4104, "R9", "wrapped tag words",
              {rx_data[1], rx_data[4]}, {16'h4001, 16'h4104});
    endtask

    task automatic t_ts_wrap_r10();
        logic [NC-1:0] m = '0;
        m[25] = 1'b1;
        cfg_delay = 8'd10;
        while ((cyc % 256) != 250) @(negedge clk);
        hit_cols(m, 16'h5000);
        trig_after(10);
        do_token(1'b0);
        check_pass("R10", m);
        check(rx_data[25] == 16'h5019, "R10", "word across wrap", rx_data[25], 16'h5019);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) cur_data[c] = '0;
        @(negedge clk);
        t_reset_r1();
        t_basic_r2();
        t_mismatch_r3();
        t_freeze_r4_r5_r6();
        t_reset_after_read_r7_r8();
        t_tag_wrap_r9();
        t_ts_wrap_r10();
        report();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        report();
        $finish;
    end
endmodule